// File: doc/BRIEF.md
# Branch target selection unit

This block sits in an instruction fetch stage and forms the next-PC guess for one control instruction per cycle. The fetch logic presents the instruction's class (unconditional, call, return, direct), its PC, the fall-through PC, the target encoded in the instruction, an address-space identifier, a thread number and a sequence number. One clock later the block answers with a taken flag, the predicted PC and a pulse that tells the direction predictor an unconditional transfer was seen.

Inside, three structures feed the decision. The first is a bimodal direction stub of two-bit counters. The second is a direct-mapped target buffer whose entries match on full PC and address-space identifier. The third is a sixteen-entry circular return stack kept separately for each thread. Every accepted prediction also writes a repair record into that thread's history queue, and commit logic drains the queue oldest first. Five counters keep totals of the events the block sees.

Top module: `brsel_unit`

## Requirements
- R1: A request is accepted when `req_valid` is high and the history queue of `req_tid` holds fewer than `HIST_DEPTH` (4) records. `req_ready` shows that condition for the presented thread. `rsp_valid` is high exactly one cycle after an accepted request, and a refused request changes no state and no counter.
- R2: An unconditional instruction that is not a return is predicted taken without reading the direction stub, subject to R7 and R8. `rsp_uncond` echoes the unconditional flag with each response.
- R3: An unconditional return whose thread's return stack is empty is predicted not taken and leaves the stack unchanged.
- R4: A non-unconditional instruction takes its direction from the MSB of a two-bit saturating counter. The counter's index bit j is the XOR of every PC bit i with i mod 6 equal to j. Counters reset to 01 and are trained by `dir_upd_*`. Each such lookup increments `cnt_cond`.
- R5: A taken return uses the top-of-stack value as its target, increments `cnt_ras`, and records the used flag, the top index and that value. It pops one entry if the stack is occupied. A taken conditional return on an empty stack uses the value in the current top slot and does not pop.
- R6: A taken call pushes its own PC on its thread's return stack and marks the record as pushed and as a call. This still happens when a target buffer miss later makes the prediction not taken.
- R7: A call that is both unconditional and direct is taken to `req_target`. It counts in `cnt_btb_lookup` but never in `cnt_btb_hit`.
- R8: Any other taken non-return increments `cnt_btb_lookup` and reads the target buffer entry indexed by PC bits [5:2]. A hit needs a valid entry with equal full PC and ASID; it supplies the target and increments `cnt_btb_hit`. A miss makes the prediction not taken.
- R9: When the final prediction is not taken, `rsp_pc` equals `req_next_pc`.
- R10: Each accepted request appends a record (sequence, PC, taken, thread, used-stack, stack index, stack value, pushed, call) to its thread's queue. `hist_*` show the oldest record of `hist_sel_tid`, `hist_valid` shows that the queue is non-empty, and `hist_pop` removes that oldest record.
- R11: `cnt_lookup` counts every accepted request.
- R12: The return stack is circular with 16 slots. A push onto a full stack overwrites the oldest entry and occupancy stays at 16, so 17 calls followed by returns give 16 taken returns, newest first, and then one not-taken return.
- R13: Return stacks and history queues are separate per thread; activity on one thread changes neither structure of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Prediction request present |
| req_ready | output | 1 | History queue of `req_tid` has room |
| req_uncond | input | 1 | Instruction is unconditional |
| req_call | input | 1 | Instruction is a call |
| req_ret | input | 1 | Instruction is a return |
| req_direct | input | 1 | Target is encoded in the instruction |
| req_pc | input | 32 | Instruction PC |
| req_next_pc | input | 32 | Fall-through PC |
| req_target | input | 32 | Encoded branch target |
| req_asid | input | 8 | Address-space identifier |
| req_tid | input | 1 | Thread number |
| req_seq | input | 16 | Sequence number |
| btb_wr_en | input | 1 | Write a target buffer entry |
| btb_wr_pc | input | 32 | PC of entry written |
| btb_wr_asid | input | 8 | ASID of entry written |
| btb_wr_target | input | 32 | Target of entry written |
| dir_upd_en | input | 1 | Train a direction counter |
| dir_upd_pc | input | 32 | PC selecting the counter |
| dir_upd_taken | input | 1 | Training outcome |
| rsp_valid | output | 1 | Response present |
| rsp_taken | output | 1 | Predicted taken |
| rsp_pc | output | 32 | Predicted next PC |
| rsp_uncond | output | 1 | Unconditional notice for the direction predictor |
| hist_sel_tid | input | 1 | Thread whose queue is shown |
| hist_pop | input | 1 | Remove oldest record of the shown queue |
| hist_valid | output | 1 | Shown queue is non-empty |
| hist_seq | output | 16 | Record sequence number |
| hist_pc | output | 32 | Record PC |
| hist_taken | output | 1 | Record taken flag |
| hist_tid | output | 1 | Record thread |
| hist_used_ras | output | 1 | Record used the return stack |
| hist_ras_idx | output | 4 | Record top-of-stack index |
| hist_ras_val | output | 32 | Record top-of-stack value |
| hist_pushed_ras | output | 1 | Record pushed the return stack |
| hist_was_call | output | 1 | Record was a call |
| cnt_lookup | output | 16 | Accepted requests |
| cnt_cond | output | 16 | Direction lookups |
| cnt_ras | output | 16 | Return stack uses |
| cnt_btb_lookup | output | 16 | Target buffer lookups |
| cnt_btb_hit | output | 16 | Target buffer hits |

## Verification
A corrupted top-of-stack pointer or occupancy count shows at the next taken return. That return reports a wrong `rsp_pc` or taken flag one cycle after acceptance, and the drained record carries the wrong index. A stale or mis-tagged target buffer entry turns into a wrong taken flag on the first indirect branch that maps to it, and a misrouted counter increment shows on the counter outputs in the same cycle as the response. History queue faults show at `hist_*` as soon as commit drains the thread, and `req_ready` exposes an occupancy error as soon as the queue nears its limit.

// File: rtl/brsel_pkg.sv
package brsel_pkg;
    localparam int ADDR_W    = 32;
    localparam int ASID_W    = 8;
    localparam int TID_W     = 1;
    localparam int SEQ_W     = 16;
    localparam int RAS_DEPTH = 16;
    localparam int RAS_IDX_W = $clog2(RAS_DEPTH);

    typedef struct packed {
        logic [SEQ_W-1:0]     seq;
        logic [ADDR_W-1:0]    pc;
        logic                 taken;
        logic [TID_W-1:0]     tid;
        logic                 used_ras;
        logic [RAS_IDX_W-1:0] ras_idx;
        logic [ADDR_W-1:0]    ras_val;
        logic                 pushed_ras;
        logic                 was_call;
    } hist_rec_t;
endpackage

// File: rtl/brsel_ras.sv
module brsel_ras #(
    parameter int DEPTH = 16,
    parameter int AW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic                     pop_i,
    input  logic [AW-1:0]            push_val_i,
    output logic [AW-1:0]            top_val_o,
    output logic [$clog2(DEPTH)-1:0] top_idx_o,
    output logic                     empty_o
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] mem_q [DEPTH];
    logic [AW-1:0] mem_d [DEPTH];
    logic [IW-1:0] top_q, top_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        mem_d = mem_q;
        top_d = top_q;
        cnt_d = cnt_q;
        if (pop_i && cnt_q != '0) begin
            top_d = top_q - IW'(1);
            cnt_d = cnt_q - CW'(1);
        end else if (push_i) begin
            top_d        = top_q + IW'(1);
            mem_d[top_d] = push_val_i;
            if (cnt_q != CW'(DEPTH)) cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            top_q <= '1;
            cnt_q <= '0;
        end else begin
            mem_q <= mem_d;
            top_q <= top_d;
            cnt_q <= cnt_d;
        end
    end

    assign top_val_o = mem_q[top_q];
    assign top_idx_o = top_q;
    assign empty_o   = (cnt_q == '0);
endmodule

// File: rtl/brsel_btb.sv
module brsel_btb #(
    parameter int ENTRIES = 16,
    parameter int AW      = 32,
    parameter int ASW     = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  look_pc_i,
    input  logic [ASW-1:0] look_asid_i,
    output logic           hit_o,
    output logic [AW-1:0]  target_o,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  wr_pc_i,
    input  logic [ASW-1:0] wr_asid_i,
    input  logic [AW-1:0]  wr_target_i
);
    localparam int IW = $clog2(ENTRIES);

    logic           val_q  [ENTRIES];
    logic           val_d  [ENTRIES];
    logic [AW-1:0]  tag_q  [ENTRIES];
    logic [AW-1:0]  tag_d  [ENTRIES];
    logic [ASW-1:0] asid_q [ENTRIES];
    logic [ASW-1:0] asid_d [ENTRIES];
    logic [AW-1:0]  tgt_q  [ENTRIES];
    logic [AW-1:0]  tgt_d  [ENTRIES];

    logic [IW-1:0] look_idx, wr_idx;
    assign look_idx = look_pc_i[IW+1:2];
    assign wr_idx   = wr_pc_i[IW+1:2];

    always_comb begin
        val_d  = val_q;
        tag_d  = tag_q;
        asid_d = asid_q;
        tgt_d  = tgt_q;
        if (wr_en_i) begin
            val_d[wr_idx]  = 1'b1;
            tag_d[wr_idx]  = wr_pc_i;
            asid_d[wr_idx] = wr_asid_i;
            tgt_d[wr_idx]  = wr_target_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                val_q[i]  <= 1'b0;
                tag_q[i]  <= '0;
                asid_q[i] <= '0;
                tgt_q[i]  <= '0;
            end
        end else begin
            val_q  <= val_d;
            tag_q  <= tag_d;
            asid_q <= asid_d;
            tgt_q  <= tgt_d;
        end
    end

    assign hit_o    = val_q[look_idx] && (tag_q[look_idx] == look_pc_i)
                      && (asid_q[look_idx] == look_asid_i);
    assign target_o = tgt_q[look_idx];
endmodule

// File: rtl/brsel_dirpred.sv
module brsel_dirpred #(
    parameter int ENTRIES = 64,
    parameter int AW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] look_pc_i,
    output logic          taken_o,
    input  logic          upd_en_i,
    input  logic [AW-1:0] upd_pc_i,
    input  logic          upd_taken_i
);
    localparam int IW = $clog2(ENTRIES);

    function automatic logic [IW-1:0] fold_pc(input logic [AW-1:0] a);
        logic [IW-1:0] r;
        r = '0;
        for (int i = 0; i < AW; i++) r[i % IW] = r[i % IW] ^ a[i];
        return r;
    endfunction

    logic [1:0] ctr_q [ENTRIES];
    logic [1:0] ctr_d [ENTRIES];
    logic [IW-1:0] upd_idx;

    assign upd_idx = fold_pc(upd_pc_i);

    always_comb begin
        ctr_d = ctr_q;
        if (upd_en_i) begin
            if (upd_taken_i && ctr_q[upd_idx] != 2'b11)
                ctr_d[upd_idx] = ctr_q[upd_idx] + 2'd1;
            else if (!upd_taken_i && ctr_q[upd_idx] != 2'b00)
                ctr_d[upd_idx] = ctr_q[upd_idx] - 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'b01;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign taken_o = ctr_q[fold_pc(look_pc_i)][1];
endmodule

// File: rtl/brsel_hist_fifo.sv
module brsel_hist_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] rec_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [W-1:0]  mem_d [DEPTH];
    logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          do_push, do_pop;

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_comb begin
        mem_d = mem_q;
        wp_d  = wp_q;
        rp_d  = rp_q;
        cnt_d = cnt_q;
        if (do_push) begin
            mem_d[wp_q] = rec_i;
            wp_d        = wp_q + PW'(1);
        end
        if (do_pop) rp_d = rp_q + PW'(1);
        if (do_push && !do_pop) cnt_d = cnt_q + CW'(1);
        else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            mem_q <= mem_d;
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    assign head_o = mem_q[rp_q];
endmodule

// File: rtl/brsel_unit.sv
module brsel_unit
    import brsel_pkg::*;
#(
    parameter int BTB_ENTRIES = 16,
    parameter int DIR_ENTRIES = 64,
    parameter int HIST_DEPTH  = 4,
    parameter int CNT_W       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_uncond,
    input  logic                 req_call,
    input  logic                 req_ret,
    input  logic                 req_direct,
    input  logic [ADDR_W-1:0]    req_pc,
    input  logic [ADDR_W-1:0]    req_next_pc,
    input  logic [ADDR_W-1:0]    req_target,
    input  logic [ASID_W-1:0]    req_asid,
    input  logic [TID_W-1:0]     req_tid,
    input  logic [SEQ_W-1:0]     req_seq,
    input  logic                 btb_wr_en,
    input  logic [ADDR_W-1:0]    btb_wr_pc,
    input  logic [ASID_W-1:0]    btb_wr_asid,
    input  logic [ADDR_W-1:0]    btb_wr_target,
    input  logic                 dir_upd_en,
    input  logic [ADDR_W-1:0]    dir_upd_pc,
    input  logic                 dir_upd_taken,
    output logic                 rsp_valid,
    output logic                 rsp_taken,
    output logic [ADDR_W-1:0]    rsp_pc,
    output logic                 rsp_uncond,
    input  logic [TID_W-1:0]     hist_sel_tid,
    input  logic                 hist_pop,
    output logic                 hist_valid,
    output logic [SEQ_W-1:0]     hist_seq,
    output logic [ADDR_W-1:0]    hist_pc,
    output logic                 hist_taken,
    output logic [TID_W-1:0]     hist_tid,
    output logic                 hist_used_ras,
    output logic [RAS_IDX_W-1:0] hist_ras_idx,
    output logic [ADDR_W-1:0]    hist_ras_val,
    output logic                 hist_pushed_ras,
    output logic                 hist_was_call,
    output logic [CNT_W-1:0]     cnt_lookup,
    output logic [CNT_W-1:0]     cnt_cond,
    output logic [CNT_W-1:0]     cnt_ras,
    output logic [CNT_W-1:0]     cnt_btb_lookup,
    output logic [CNT_W-1:0]     cnt_btb_hit
);
    localparam int NT = 1 << TID_W;
    localparam int HW = $bits(hist_rec_t);

    typedef struct packed {
        logic              rsp_valid;
        logic              rsp_taken;
        logic [ADDR_W-1:0] rsp_pc;
        logic              rsp_uncond;
        logic [CNT_W-1:0]  n_lookup;
        logic [CNT_W-1:0]  n_cond;
        logic [CNT_W-1:0]  n_ras;
        logic [CNT_W-1:0]  n_btb_lookup;
        logic [CNT_W-1:0]  n_btb_hit;
    } unit_state_t;

    unit_state_t st_q, st_d;

    logic [NT-1:0]        hq_full, hq_empty, hq_push, hq_pop;
    logic [HW-1:0]        hq_head [NT];
    logic [NT-1:0]        ras_empty, ras_push, ras_pop;
    logic [ADDR_W-1:0]    ras_top_val [NT];
    logic [RAS_IDX_W-1:0] ras_top_idx [NT];
    hist_rec_t            rec_new, head_sel;
    logic                 dir_taken, btb_hit, accept;
    logic [ADDR_W-1:0]    btb_tgt;

    brsel_dirpred #(.ENTRIES(DIR_ENTRIES), .AW(ADDR_W)) u_dir (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_pc_i   (req_pc),
        .taken_o     (dir_taken),
        .upd_en_i    (dir_upd_en),
        .upd_pc_i    (dir_upd_pc),
        .upd_taken_i (dir_upd_taken)
    );

    brsel_btb #(.ENTRIES(BTB_ENTRIES), .AW(ADDR_W), .ASW(ASID_W)) u_btb (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_pc_i   (req_pc),
        .look_asid_i (req_asid),
        .hit_o       (btb_hit),
        .target_o    (btb_tgt),
        .wr_en_i     (btb_wr_en),
        .wr_pc_i     (btb_wr_pc),
        .wr_asid_i   (btb_wr_asid),
        .wr_target_i (btb_wr_target)
    );

    for (genvar t = 0; t < NT; t++) begin : g_thread
        brsel_ras #(.DEPTH(RAS_DEPTH), .AW(ADDR_W)) u_ras (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_i     (ras_push[t]),
            .pop_i      (ras_pop[t]),
            .push_val_i (req_pc),
            .top_val_o  (ras_top_val[t]),
            .top_idx_o  (ras_top_idx[t]),
            .empty_o    (ras_empty[t])
        );
        brsel_hist_fifo #(.DEPTH(HIST_DEPTH), .W(HW)) u_hq (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (hq_push[t]),
            .rec_i   (rec_new),
            .pop_i   (hq_pop[t]),
            .head_o  (hq_head[t]),
            .full_o  (hq_full[t]),
            .empty_o (hq_empty[t])
        );
    end

    assign req_ready = !hq_full[req_tid];
    assign accept    = req_valid && req_ready;

    always_comb begin
        logic              taken;
        logic [ADDR_W-1:0] target;
        st_d           = st_q;
        st_d.rsp_valid = accept;
        ras_push       = '0;
        ras_pop        = '0;
        hq_push        = '0;
        hq_pop         = '0;
        rec_new        = '0;
        taken          = 1'b0;
        target         = req_next_pc;
        if (hist_pop) hq_pop[hist_sel_tid] = 1'b1;
        if (accept) begin
            st_d.n_lookup = st_q.n_lookup + CNT_W'(1);
            if (req_uncond) begin
                taken = !(req_ret && ras_empty[req_tid]);
            end else begin
                taken       = dir_taken;
                st_d.n_cond = st_q.n_cond + CNT_W'(1);
            end
            if (taken) begin
                if (req_ret) begin
                    target           = ras_top_val[req_tid];
                    ras_pop[req_tid] = !ras_empty[req_tid];
                    st_d.n_ras       = st_q.n_ras + CNT_W'(1);
                    rec_new.used_ras = 1'b1;
                    rec_new.ras_idx  = ras_top_idx[req_tid];
                    rec_new.ras_val  = ras_top_val[req_tid];
                end else begin
                    st_d.n_btb_lookup = st_q.n_btb_lookup + CNT_W'(1);
                    if (req_call) begin
                        ras_push[req_tid]  = 1'b1;
                        rec_new.pushed_ras = 1'b1;
                        rec_new.was_call   = 1'b1;
                    end
                    if (req_call && req_uncond && req_direct) begin
                        target = req_target;
                    end else if (btb_hit) begin
                        target         = btb_tgt;
                        st_d.n_btb_hit = st_q.n_btb_hit + CNT_W'(1);
                    end else begin
                        taken = 1'b0;
                    end
                end
            end
            st_d.rsp_taken   = taken;
            st_d.rsp_pc      = taken ? target : req_next_pc;
            st_d.rsp_uncond  = req_uncond;
            rec_new.seq      = req_seq;
            rec_new.pc       = req_pc;
            rec_new.taken    = taken;
            rec_new.tid      = req_tid;
            hq_push[req_tid] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_sel        = hist_rec_t'(hq_head[hist_sel_tid]);
    assign hist_valid      = !hq_empty[hist_sel_tid];
    assign hist_seq        = head_sel.seq;
    assign hist_pc         = head_sel.pc;
    assign hist_taken      = head_sel.taken;
    assign hist_tid        = head_sel.tid;
    assign hist_used_ras   = head_sel.used_ras;
    assign hist_ras_idx    = head_sel.ras_idx;
    assign hist_ras_val    = head_sel.ras_val;
    assign hist_pushed_ras = head_sel.pushed_ras;
    assign hist_was_call   = head_sel.was_call;

    assign rsp_valid      = st_q.rsp_valid;
    assign rsp_taken      = st_q.rsp_taken;
    assign rsp_pc         = st_q.rsp_pc;
    assign rsp_uncond     = st_q.rsp_uncond;
    assign cnt_lookup     = st_q.n_lookup;
    assign cnt_cond       = st_q.n_cond;
    assign cnt_ras        = st_q.n_ras;
    assign cnt_btb_lookup = st_q.n_btb_lookup;
    assign cnt_btb_hit    = st_q.n_btb_hit;
endmodule

// File: rtl/brsel_unit_chk.sv
module brsel_unit_chk
    import brsel_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_uncond,
    input logic              req_call,
    input logic              req_ret,
    input logic              req_direct,
    input logic [ADDR_W-1:0] req_next_pc,
    input logic [ADDR_W-1:0] req_target,
    input logic              rsp_valid,
    input logic              rsp_taken,
    input logic [ADDR_W-1:0] rsp_pc,
    input logic              hist_valid,
    input logic              hist_pop,
    input logic [TID_W-1:0]  hist_sel_tid,
    input logic [CNT_W-1:0]  cnt_lookup,
    input logic [CNT_W-1:0]  cnt_btb_lookup,
    input logic [CNT_W-1:0]  cnt_btb_hit
);
    a_r1_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    a_r1_no_resp_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);

    a_r7_direct_call_target: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_uncond && req_call && req_direct && !req_ret)
        |=> (rsp_taken && rsp_pc == $past(req_target)));

    a_r9_not_taken_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_taken || rsp_pc == $past(req_next_pc)));

    a_r8_hits_within_lookups: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_btb_hit <= cnt_btb_lookup);

    a_r11_lookup_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cnt_lookup == $past(cnt_lookup) + CNT_W'(1)));

    a_r10_queue_holds_until_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_valid && !hist_pop) |=> (hist_valid || !$stable(hist_sel_tid)));
endmodule

bind brsel_unit brsel_unit_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/brsel_unit_test.sv
module brsel_unit_test;
    import brsel_pkg::*;

    localparam int HQD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_uncond = 0, req_call = 0, req_ret = 0, req_direct = 0;
    logic        req_ready;
    logic [31:0] req_pc = 0, req_next_pc = 0, req_target = 0;
    logic [7:0]  req_asid = 0;
    logic [0:0]  req_tid = 0;
    logic [15:0] req_seq = 0;
    logic        btb_wr_en = 0;
    logic [31:0] btb_wr_pc = 0, btb_wr_target = 0;
    logic [7:0]  btb_wr_asid = 0;
    logic        dir_upd_en = 0, dir_upd_taken = 0;
    logic [31:0] dir_upd_pc = 0;
    logic        rsp_valid, rsp_taken, rsp_uncond;
    logic [31:0] rsp_pc;
    logic [0:0]  hist_sel_tid = 0;
    logic        hist_pop = 0;
    logic        hist_valid, hist_taken, hist_used_ras, hist_pushed_ras, hist_was_call;
    logic [15:0] hist_seq;
    logic [31:0] hist_pc, hist_ras_val;
    logic [0:0]  hist_tid;
    logic [3:0]  hist_ras_idx;
    logic [15:0] cnt_lookup, cnt_cond, cnt_ras, cnt_btb_lookup, cnt_btb_hit;

    always #4 clk = ~clk;

    brsel_unit uut (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] m_ras [2][16];
    int          m_top [2];
    int          m_cnt [2];
    logic [1:0]  m_dir [64];
    bit          m_bv [16];
    logic [31:0] m_bpc [16];
    logic [7:0]  m_basid [16];
    logic [31:0] m_btgt [16];
    hist_rec_t   m_hq [2][$];
    int c_look = 0, c_cond = 0, c_ras = 0, c_btbl = 0, c_btbh = 0;
    logic [15:0] seq_n = 16'h100;

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int fold6(logic [31:0] a);
        int r = 0;
        for (int i = 0; i < 32; i++) if (a[i]) r = r ^ (1 << (i % 6));
        return r;
    endfunction

    task automatic chk_counters(string rq);
        chk(rq, "cnt_lookup", cnt_lookup, c_look);
        chk(rq, "cnt_cond", cnt_cond, c_cond);
        chk(rq, "cnt_ras", cnt_ras, c_ras);
        chk(rq, "cnt_btb_lookup", cnt_btb_lookup, c_btbl);
        chk(rq, "cnt_btb_hit", cnt_btb_hit, c_btbh);
    endtask

    task automatic do_req(string rq, bit unc, bit call, bit ret, bit dir,
                          logic [31:0] pc, logic [7:0] asid, int t, logic [31:0] tgt);
        logic [31:0] nxt, target;
        bit rdy, tk;
        int bi;
        hist_rec_t r;
        nxt = pc + 32'd4;
        @(negedge clk);
        req_valid = 1; req_uncond = unc; req_call = call; req_ret = ret; req_direct = dir;
        req_pc = pc; req_next_pc = nxt; req_target = tgt; req_asid = asid;
        req_tid = 1'(t); req_seq = seq_n;
        #1;
        rdy = (m_hq[t].size() < HQD);
        chk(rq, "req_ready", req_ready, rdy);
        r = '0;
        target = nxt;
        tk = 0;
        if (rdy) begin
            c_look++;
            if (unc) tk = !(ret && m_cnt[t] == 0);
            else begin tk = m_dir[fold6(pc)][1]; c_cond++; end
            if (tk) begin
                if (ret) begin
                    c_ras++;
                    r.used_ras = 1; r.ras_idx = 4'(m_top[t]); r.ras_val = m_ras[t][m_top[t]];
                    target = m_ras[t][m_top[t]];
                    if (m_cnt[t] > 0) begin m_top[t] = (m_top[t] + 15) % 16; m_cnt[t]--; end
                end else begin
                    c_btbl++;
                    if (call) begin
                        m_top[t] = (m_top[t] + 1) % 16;
                        m_ras[t][m_top[t]] = pc;
                        if (m_cnt[t] < 16) m_cnt[t]++;
                        r.pushed_ras = 1; r.was_call = 1;
                    end
                    bi = int'(pc[5:2]);
                    if (call && unc && dir) target = tgt;
                    else if (m_bv[bi] && m_bpc[bi] == pc && m_basid[bi] == asid) begin
                        target = m_btgt[bi]; c_btbh++;
                    end else tk = 0;
                end
            end
            r.seq = seq_n; r.pc = pc; r.taken = tk; r.tid = 1'(t);
            m_hq[t].push_back(r);
            seq_n++;
        end
        @(negedge clk);
        req_valid = 0;
        chk(rq, "rsp_valid", rsp_valid, rdy);
        if (rdy) begin
            chk(rq, "rsp_taken", rsp_taken, tk);
            chk(rq, "rsp_pc", rsp_pc, tk ? target : nxt);
            chk(rq, "rsp_uncond", rsp_uncond, unc);
        end
        chk_counters(rq);
    endtask

    task automatic drain(string rq, int t);
        hist_rec_t e;
        while (m_hq[t].size() > 0) begin
            @(negedge clk);
            hist_sel_tid = 1'(t);
            #1;
            e = m_hq[t][0];
            chk(rq, "hist_valid", hist_valid, 1);
            chk(rq, "hist_seq", hist_seq, e.seq);
            chk(rq, "hist_pc", hist_pc, e.pc);
            chk(rq, "hist_ras_val", hist_ras_val, e.ras_val);
            chk(rq, "hist_flags",
                {hist_taken, hist_tid, hist_used_ras, hist_ras_idx, hist_pushed_ras, hist_was_call},
                {e.taken, e.tid, e.used_ras, e.ras_idx, e.pushed_ras, e.was_call});
            hist_pop = 1;
            @(negedge clk);
            hist_pop = 0;
            void'(m_hq[t].pop_front());
        end
        @(negedge clk);
        hist_sel_tid = 1'(t);
        #1;
        chk(rq, "hist_valid empty", hist_valid, 0);
    endtask

    task automatic btb_write(logic [31:0] pc, logic [7:0] asid, logic [31:0] tgt);
        @(negedge clk);
        btb_wr_en = 1; btb_wr_pc = pc; btb_wr_asid = asid; btb_wr_target = tgt;
        @(negedge clk);
        btb_wr_en = 0;
        m_bv[pc[5:2]] = 1; m_bpc[pc[5:2]] = pc; m_basid[pc[5:2]] = asid; m_btgt[pc[5:2]] = tgt;
    endtask

    task automatic dir_train(logic [31:0] pc, bit tk);
        int ix;
        @(negedge clk);
        dir_upd_en = 1; dir_upd_pc = pc; dir_upd_taken = tk;
        @(negedge clk);
        dir_upd_en = 0;
        ix = fold6(pc);
        if (tk && m_dir[ix] != 2'b11) m_dir[ix] = m_dir[ix] + 2'd1;
        else if (!tk && m_dir[ix] != 2'b00) m_dir[ix] = m_dir[ix] - 2'd1;
    endtask

    initial begin
        for (int t = 0; t < 2; t++) begin
            m_top[t] = 15; m_cnt[t] = 0;
            for (int i = 0; i < 16; i++) m_ras[t][i] = '0;
        end
        for (int i = 0; i < 64; i++) m_dir[i] = 2'b01;
        for (int i = 0; i < 16; i++) begin
            m_bv[i] = 0; m_bpc[i] = '0; m_basid[i] = '0; m_btgt[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state (R1, R10, R11)
        chk("R1", "ready after reset", req_ready, 1);
        chk("R1", "rsp_valid after reset", rsp_valid, 0);
        chk("R10", "hist_valid after reset", hist_valid, 0);
        chk_counters("R11");

        // R4 R9: counter at 01 predicts not taken
        do_req("R4", 0, 0, 0, 0, 32'h100, 8'd3, 0, 0);
        dir_train(32'h100, 1);
        dir_train(32'h100, 1);
        // R8: taken direction but target buffer empty
        do_req("R8", 0, 0, 0, 0, 32'h100, 8'd3, 0, 0);
        btb_write(32'h100, 8'd3, 32'h2000);
        do_req("R8", 0, 0, 0, 0, 32'h100, 8'd3, 0, 0);
        do_req("R8", 0, 0, 0, 0, 32'h100, 8'd4, 0, 0);
        drain("R10", 0);
        // R7 R6: direct call, then indirect call missing in buffer
        do_req("R7", 1, 1, 0, 1, 32'h400, 8'd3, 0, 32'h800);
        do_req("R6", 1, 1, 0, 0, 32'h500, 8'd3, 0, 32'h900);
        // R5 R3: returns pop newest first, then empty
        do_req("R5", 1, 0, 1, 0, 32'h880, 8'd3, 0, 0);
        drain("R10", 0);
        do_req("R5", 1, 0, 1, 0, 32'h884, 8'd3, 0, 0);
        do_req("R3", 1, 0, 1, 0, 32'h888, 8'd3, 0, 0);
        // R2: unconditional indirect jump hits buffer
        do_req("R2", 1, 0, 0, 0, 32'h100, 8'd3, 0, 0);
        drain("R10", 0);

        // R13: thread 1 stack is separate
        do_req("R13", 1, 1, 0, 1, 32'h600, 8'd1, 0, 32'h700);
        do_req("R13", 1, 0, 1, 0, 32'h604, 8'd1, 1, 0);
        // R1: fill thread 1 queue, next request refused, thread 0 still served
        do_req("R1", 0, 0, 0, 0, 32'h208, 8'd1, 1, 0);
        do_req("R1", 0, 0, 0, 0, 32'h20c, 8'd1, 1, 0);
        do_req("R1", 0, 0, 0, 0, 32'h210, 8'd1, 1, 0);
        do_req("R1", 1, 1, 0, 1, 32'h214, 8'd1, 1, 32'h300);
        do_req("R13", 1, 0, 1, 0, 32'h608, 8'd1, 0, 0);
        drain("R10", 1);
        drain("R10", 0);

        // R12: 17 calls on thread 1, then 17 returns
        for (int i = 0; i < 17; i++) begin
            do_req("R12", 1, 1, 0, 1, 32'h1000 + 32'(4 * i), 8'd2, 1, 32'h4000);
            drain("R12", 1);
        end
        for (int i = 0; i < 17; i++) begin
            do_req("R12", 1, 0, 1, 0, 32'h3000 + 32'(4 * i), 8'd2, 1, 0);
            drain("R12", 1);
        end
        // R5: taken conditional return on empty stack reads the top slot
        dir_train(32'h3100, 1);
        dir_train(32'h3100, 1);
        do_req("R5", 0, 0, 1, 0, 32'h3100, 8'd2, 1, 0);
        do_req("R5", 0, 0, 1, 0, 32'h3100, 8'd2, 1, 0);
        drain("R5", 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule